// File: doc/BRIEF.md
# Per-Chunk Page ECC Generator

This block watches the byte stream of a NAND page transfer and builds a single-error-correcting Hamming code for every 512-byte chunk of the page. An operation is armed when the command stream shows one of two programmable start opcodes: one for page programming and one for page reading. Arming needs the engine to be enabled and a supported page size to be selected. While armed, the engine takes in one byte per data beat. It splits the stream into chunks and commits one 32-bit result word per chunk. The result words hold a valid flag, a correctable flag, a failed flag and the 24-bit code in inverted form.

The page size code on `cfgPageSel` gives 1, 2 or 4 chunks (512 B, 1 KiB and 2 KiB). The mode field `cfgMode` either bypasses the engine or enables it. The two enabled modes (register-access and memory) behave the same here. The transfer ends in one of two ways: the page's last chunk fills, or a beat carries `dataLast`. A last beat that ends a chunk early marks that chunk as failed. Correcting data with these codes is done elsewhere.

Top module: `page_ecc_gen`

## Requirements
- R1: After reset `eccBusy` is 0 and every result word on `eccValues` is 0.
- R2: A command beat whose opcode equals `opWrStart` or `opRdStart` arms the engine when `cfgMode` is nonzero and `cfgPageSel` is 1, 2 or 3. On the next cycle `eccBusy` is 1 and every result word is 0. Other opcodes have no effect.
- R3: With `cfgMode` = 0 (bypass) or `cfgPageSel` = 0, start opcodes are ignored: `eccBusy` stays 0 and the result words keep their values.
- R4: Take a data bit at address A = byte index within the chunk × 8 + bit index (12 bits). It feeds the odd parity bit k when bit k of A is 1, and the even parity bit k when bit k of A is 0. The word holds the inverted odd bits in [11:0] and the inverted even bits in [23:12].
- R5: When the 512th byte of a chunk is taken in, the chunk's word shows bit 30 (valid) = 1, bit 27 (correctable) = 1 and bit 28 (failed) = 0. This is visible the cycle after that byte.
- R6: `cfgPageSel` values 1, 2 and 3 give 1, 2 and 4 chunks. Chunk k is written to word k (`eccValues[32k+31:32k]`). When the page's final chunk fills, `eccBusy` falls, even without `dataLast`. Any further bytes are ignored.
- R7: A beat with `dataLast` that does not complete a chunk closes that chunk with bit 30 = 1, bit 28 = 1, bit 27 = 0. The code covers only the bytes received, and `eccBusy` falls.
- R8: Data beats while the engine is idle change no result word.
- R9: If a start opcode and a data beat arrive in the same cycle, the start wins. That byte is discarded and the count starts again at byte 0 of chunk 0.
- R10: A start opcode while busy restarts the page: every word is cleared and counting starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPageSel | input | 2 | Page size code: 1=512 B, 2=1 KiB, 3=2 KiB, 0=unsupported |
| cfgMode | input | 2 | 0 = bypass; bit 0 register-access mode, bit 1 memory mode |
| opWrStart | input | 8 | Opcode that starts a page program |
| opRdStart | input | 8 | Opcode that starts a page read |
| cmdValid | input | 1 | A command opcode is present this cycle |
| cmdCode | input | 8 | Observed command opcode |
| dataValid | input | 1 | A data byte is present this cycle |
| dataByte | input | 8 | Data byte |
| dataLast | input | 1 | This beat is the final data access of the page |
| eccBusy | output | 1 | Engine is armed and still computing |
| eccValues | output | MAX_CHUNKS*32 | Result words, chunk k in bits [32k+31:32k] |

## Verification
A start opcode and a data beat can fall in the same cycle. This happens when a new command follows a transfer without a gap, or when a restart overlaps the stream. The bench drives a nonzero byte together with the start opcode on one clock edge and then sends a full chunk. It judges the result by comparing the committed code with the code of that chunk alone. A byte wrongly absorbed would shift every later byte address and change the code. The same concern applies to a restart after a committed chunk: the bench checks that the old word is cleared in the cycle after the restart.

// File: rtl/page_ecc_pkg.sv
package page_ecc_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned VALID_POS = 30;
  localparam int unsigned FAIL_POS  = 28;
  localparam int unsigned CORR_POS  = 27;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } eccState_t;

  typedef struct packed {
    logic clearAll;
    logic absorb;
    logic first;
    logic commit;
    logic partial;
  } eccStrobe_t;

endpackage

// File: rtl/page_ecc_ctrl.sv
module page_ecc_ctrl
  import page_ecc_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 512,
  parameter int unsigned MAX_CHUNKS  = 4,
  localparam int unsigned BYTE_W = $clog2(CHUNK_BYTES),
  localparam int unsigned CIDX_W = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgPageSel,
  input  logic [1:0]        cfgMode,
  input  logic [7:0]        opWrStart,
  input  logic [7:0]        opRdStart,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic              dataValid,
  input  logic              dataLast,
  output eccStrobe_t        strobe,
  output logic [BYTE_W-1:0] byteIdx,
  output logic [CIDX_W-1:0] chunkIdx,
  output logic              busy
);

  eccState_t         state;
  logic [BYTE_W-1:0] byteCnt;
  logic [CIDX_W-1:0] chunkCnt;
  logic [CIDX_W:0]   pageLimit;
  logic [CIDX_W:0]   pageChunks;
  logic              startHit;
  logic              beat;
  logic              chunkEnd;
  logic              closing;
  logic              lastChunk;

  always_comb begin
    case (cfgPageSel)
      2'd1:    pageChunks = (CIDX_W+1)'(1);
      2'd2:    pageChunks = (CIDX_W+1)'(2);
      2'd3:    pageChunks = (CIDX_W+1)'(4);
      default: pageChunks = '0;
    endcase
    if (pageChunks > (CIDX_W+1)'(MAX_CHUNKS)) pageChunks = (CIDX_W+1)'(MAX_CHUNKS);
  end

  assign startHit  = cmdValid && ((cmdCode == opWrStart) || (cmdCode == opRdStart))
                     && (cfgMode != 2'd0) && (pageChunks != '0);
  assign beat      = (state == ST_RUN) && dataValid && !startHit;
  assign chunkEnd  = (byteCnt == BYTE_W'(CHUNK_BYTES - 1));
  assign closing   = beat && (chunkEnd || dataLast);
  assign lastChunk = (({1'b0, chunkCnt} + (CIDX_W+1)'(1)) == pageLimit);

  always_comb begin
    strobe.clearAll = startHit;
    strobe.absorb   = beat;
    strobe.first    = (byteCnt == '0);
    strobe.commit   = closing;
    strobe.partial  = !chunkEnd;
  end

  assign byteIdx  = byteCnt;
  assign chunkIdx = chunkCnt;
  assign busy     = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      byteCnt   <= '0;
      chunkCnt  <= '0;
      pageLimit <= '0;
    end else if (startHit) begin
      state     <= ST_RUN;
      byteCnt   <= '0;
      chunkCnt  <= '0;
      pageLimit <= pageChunks;
    end else if (beat) begin
      if (closing) begin
        byteCnt <= '0;
        if (dataLast || lastChunk) begin
          state    <= ST_IDLE;
          chunkCnt <= '0;
        end else begin
          chunkCnt <= chunkCnt + CIDX_W'(1);
        end
      end else begin
        byteCnt <= byteCnt + BYTE_W'(1);
      end
    end
  end

endmodule

// File: rtl/page_ecc_datapath.sv
module page_ecc_datapath
  import page_ecc_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 512,
  parameter int unsigned MAX_CHUNKS  = 4,
  localparam int unsigned BYTE_W = $clog2(CHUNK_BYTES),
  localparam int unsigned ADDR_W = BYTE_W + 3,
  localparam int unsigned CIDX_W = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  eccStrobe_t                   strobe,
  input  logic [BYTE_W-1:0]            byteIdx,
  input  logic [CIDX_W-1:0]            chunkIdx,
  input  logic [7:0]                   dataByte,
  output logic [MAX_CHUNKS*WORD_W-1:0] valueFlat
);

  logic [ADDR_W-1:0] accOdd, accEven;
  logic [ADDR_W-1:0] cOdd, cEven;
  logic [ADDR_W-1:0] nextOdd, nextEven;
  logic              bytePar;
  logic [WORD_W-1:0] commitWord;

  // Contribution of one byte: bit-index address bits use a masked XOR,
  // byte-index address bits steer the whole byte parity.
  always_comb begin
    cOdd    = '0;
    cEven   = '0;
    bytePar = ^dataByte;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> k) & 1) == 1) cOdd[k]  = cOdd[k]  ^ dataByte[b];
        else                     cEven[k] = cEven[k] ^ dataByte[b];
      end
    end
    for (int k = 3; k < ADDR_W; k++) begin
      if (byteIdx[k-3]) cOdd[k]  = bytePar;
      else              cEven[k] = bytePar;
    end
  end

  assign nextOdd  = (strobe.first ? '0 : accOdd)  ^ cOdd;
  assign nextEven = (strobe.first ? '0 : accEven) ^ cEven;

  always_comb begin
    commitWord = '0;
    commitWord[VALID_POS] = 1'b1;
    commitWord[FAIL_POS]  = strobe.partial;
    commitWord[CORR_POS]  = !strobe.partial;
    commitWord[ADDR_W-1:0]        = ~nextOdd;
    commitWord[2*ADDR_W-1:ADDR_W] = ~nextEven;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOdd  <= '0;
      accEven <= '0;
    end else if (strobe.absorb) begin
      accOdd  <= nextOdd;
      accEven <= nextEven;
    end
  end

  for (genvar g = 0; g < MAX_CHUNKS; g++) begin : gWord
    logic [WORD_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         word <= '0;
      else if (strobe.clearAll)                          word <= '0;
      else if (strobe.commit && chunkIdx == CIDX_W'(g))  word <= commitWord;
    end
    assign valueFlat[g*WORD_W +: WORD_W] = word;
  end

endmodule

// File: rtl/page_ecc_gen.sv
module page_ecc_gen
  import page_ecc_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 512,
  parameter int unsigned MAX_CHUNKS  = 4,
  localparam int unsigned BYTE_W = $clog2(CHUNK_BYTES),
  localparam int unsigned CIDX_W = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               cfgPageSel,
  input  logic [1:0]               cfgMode,
  input  logic [7:0]               opWrStart,
  input  logic [7:0]               opRdStart,
  input  logic                     cmdValid,
  input  logic [7:0]               cmdCode,
  input  logic                     dataValid,
  input  logic [7:0]               dataByte,
  input  logic                     dataLast,
  output logic                     eccBusy,
  output logic [MAX_CHUNKS*32-1:0] eccValues
);

  eccStrobe_t        strobe;
  logic [BYTE_W-1:0] byteIdx;
  logic [CIDX_W-1:0] chunkIdx;

  page_ecc_ctrl #(.CHUNK_BYTES(CHUNK_BYTES), .MAX_CHUNKS(MAX_CHUNKS)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgPageSel(cfgPageSel), .cfgMode(cfgMode),
    .opWrStart(opWrStart), .opRdStart(opRdStart), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .dataValid(dataValid), .dataLast(dataLast),
    .strobe(strobe), .byteIdx(byteIdx), .chunkIdx(chunkIdx), .busy(eccBusy)
  );

  page_ecc_datapath #(.CHUNK_BYTES(CHUNK_BYTES), .MAX_CHUNKS(MAX_CHUNKS)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIdx(byteIdx),
    .chunkIdx(chunkIdx), .dataByte(dataByte), .valueFlat(eccValues)
  );

endmodule

// File: rtl/page_ecc_gen_chk.sv
module page_ecc_gen_chk #(
  parameter int unsigned CHUNK_BYTES = 512,
  parameter int unsigned MAX_CHUNKS  = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [1:0]               cfgPageSel,
  input logic [1:0]               cfgMode,
  input logic [7:0]               opWrStart,
  input logic [7:0]               opRdStart,
  input logic                     cmdValid,
  input logic [7:0]               cmdCode,
  input logic                     dataValid,
  input logic                     eccBusy,
  input logic [MAX_CHUNKS*32-1:0] eccValues
);

  logic armReq;
  assign armReq = cmdValid && ((cmdCode == opWrStart) || (cmdCode == opRdStart))
                  && (cfgMode != 2'd0) && (cfgPageSel != 2'd0);

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> (eccBusy && (eccValues == '0)));  // R2

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!eccBusy && (cfgMode == 2'd0)) |=> !eccBusy);  // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!eccBusy && !armReq) |=> $stable(eccValues));  // R8

  AST_FALL_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eccBusy) |-> $past(dataValid));  // R6

  for (genvar g = 0; g < MAX_CHUNKS; g++) begin : gChunk
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
      !(eccValues[g*32+28] && eccValues[g*32+27]));  // R7
    AST_VALID_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (eccValues[g*32+28] || eccValues[g*32+27]) == eccValues[g*32+30]);  // R5
  end

endmodule

bind page_ecc_gen page_ecc_gen_chk #(.CHUNK_BYTES(CHUNK_BYTES), .MAX_CHUNKS(MAX_CHUNKS)) uChk (
  .clk(clk), .rstN(rstN), .cfgPageSel(cfgPageSel), .cfgMode(cfgMode),
  .opWrStart(opWrStart), .opRdStart(opRdStart), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .dataValid(dataValid), .eccBusy(eccBusy),
  .eccValues(eccValues)
);

// File: tb/sim_page_ecc_gen.sv
module sim_page_ecc_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CHUNK = 512;
  localparam int NCH = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       cfgPageSel, cfgMode;
  logic [7:0]       opWrStart, opRdStart;
  logic             cmdValid;
  logic [7:0]       cmdCode;
  logic             dataValid;
  logic [7:0]       dataByte;
  logic             dataLast;
  logic             eccBusy;
  logic [NCH*32-1:0] eccValues;

  int nChecks = 0;
  int nErrors = 0;
  logic [7:0]  pat [CHUNK];
  logic [31:0] expW [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_ecc_gen #(.CHUNK_BYTES(CHUNK), .MAX_CHUNKS(NCH)) u0 (
    .clk(clk), .rstN(rstN), .cfgPageSel(cfgPageSel), .cfgMode(cfgMode),
    .opWrStart(opWrStart), .opRdStart(opRdStart), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .dataValid(dataValid), .dataByte(dataByte),
    .dataLast(dataLast), .eccBusy(eccBusy), .eccValues(eccValues)
  );

  function automatic logic [31:0] wordOf(int c);
    return eccValues[c*32 +: 32];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fillPat(input int seed);
    for (int i = 0; i < CHUNK; i++) pat[i] = 8'(i * seed * 13 + seed + (i >> 4) * 29);
  endtask

  // Reference word computed bit by bit from the address definition.
  function automatic logic [31:0] refWord(input int n, input bit partial);
    logic [11:0] odd = '0;
    logic [11:0] even = '0;
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (pat[i][b]) begin
          int a = i * 8 + b;
          for (int k = 0; k < 12; k++) begin
            if (((a >> k) & 1) == 1) odd[k] = ~odd[k];
            else                     even[k] = ~even[k];
          end
        end
      end
    end
    w[30] = 1'b1;
    w[28] = partial;
    w[27] = !partial;
    w[11:0] = ~odd;
    w[23:12] = ~even;
    return w;
  endfunction

  task automatic startCmd(input logic [7:0] code);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode  = code;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = 8'hFF;
  endtask

  task automatic sendChunk(input int n, input bit last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dataValid = 1'b1;
      dataByte  = pat[i];
      dataLast  = last && (i == n - 1);
    end
    @(negedge clk);
    dataValid = 1'b0;
    dataLast  = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    cfgPageSel = 2'd1; cfgMode = 2'd1;
    opWrStart = 8'h80; opRdStart = 8'h00;
    cmdValid = 1'b0; cmdCode = 8'hFF;
    dataValid = 1'b0; dataByte = '0; dataLast = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 32'(eccBusy), 0);
    for (int c = 0; c < NCH; c++) check("R1 word", wordOf(c), 0);

    // R8 data while idle
    fillPat(11);
    sendChunk(10, 1);
    check("R8 busy", 32'(eccBusy), 0);
    check("R8 word0", wordOf(0), 0);

    // R3 bypass mode and unsupported page code
    cfgMode = 2'd0;
    startCmd(8'h80);
    check("R3 bypass busy", 32'(eccBusy), 0);
    sendChunk(CHUNK, 1);
    check("R3 bypass word0", wordOf(0), 0);
    cfgMode = 2'd2; cfgPageSel = 2'd0;
    startCmd(8'h00);
    check("R3 page0 busy", 32'(eccBusy), 0);
    cfgPageSel = 2'd1;

    // R2 non-start opcode
    startCmd(8'h30);
    check("R2 other opcode busy", 32'(eccBusy), 0);

    // R4 R5 single-bit sweep over every address bit plus both ends
    for (int s = 0; s < 14; s++) begin
      int a = (s == 12) ? 0 : (s == 13) ? 4095 : (1 << s);
      logic [31:0] ew;
      for (int i = 0; i < CHUNK; i++) pat[i] = '0;
      pat[a / 8][a % 8] = 1'b1;
      startCmd((s % 2 == 0) ? 8'h80 : 8'h00);
      check("R2 armed busy", 32'(eccBusy), 1);
      sendChunk(CHUNK, 1);
      ew = (32'h1 << 30) | (32'h1 << 27) | (32'(a & 12'hFFF) << 12) | 32'((~a) & 12'hFFF);
      check("R4 single-bit code", wordOf(0), ew);
      check("R5 done busy", 32'(eccBusy), 0);
    end

    // R6 2 KiB page by read start, four chunks, last flag on final only
    cfgPageSel = 2'd3;
    startCmd(8'h00);
    for (int c = 0; c < NCH; c++) begin
      fillPat(3 + 2 * c);
      expW[c] = refWord(CHUNK, 0);
      sendChunk(CHUNK, c == NCH - 1);
      check("R5 chunk word", wordOf(c), expW[c]);
      check("R6 busy per chunk", 32'(eccBusy), (c == NCH - 1) ? 1'b0 : 1'b1);
    end
    for (int c = 0; c < NCH; c++) check("R6 2K word", wordOf(c), expW[c]);
    fillPat(99);
    sendChunk(20, 0);
    for (int c = 0; c < NCH; c++) check("R6 R8 extra bytes", wordOf(c), expW[c]);

    // R6 1 KiB page ends without last flag; start clears old words
    cfgPageSel = 2'd2;
    startCmd(8'h80);
    for (int c = 0; c < NCH; c++) check("R2 cleared", wordOf(c), 0);
    for (int c = 0; c < 2; c++) begin
      fillPat(21 + c);
      expW[c] = refWord(CHUNK, 0);
      sendChunk(CHUNK, 0);
    end
    check("R6 1K busy", 32'(eccBusy), 0);
    check("R6 1K word0", wordOf(0), expW[0]);
    check("R6 1K word1", wordOf(1), expW[1]);
    check("R6 1K word2", wordOf(2), 0);

    // R7 early last in chunk 1
    cfgPageSel = 2'd3;
    startCmd(8'h00);
    fillPat(41);
    expW[0] = refWord(CHUNK, 0);
    sendChunk(CHUNK, 0);
    fillPat(43);
    expW[1] = refWord(100, 1);
    sendChunk(100, 1);
    check("R7 busy", 32'(eccBusy), 0);
    check("R7 word0", wordOf(0), expW[0]);
    check("R7 partial word1", wordOf(1), expW[1]);
    check("R7 word2", wordOf(2), 0);

    // R9 start and data in the same cycle
    cfgPageSel = 2'd1;
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 8'h80;
    dataValid = 1'b1; dataByte = 8'hA5;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 8'hFF; dataValid = 1'b0;
    check("R9 busy", 32'(eccBusy), 1);
    fillPat(57);
    expW[0] = refWord(CHUNK, 0);
    sendChunk(CHUNK, 1);
    check("R9 collided byte dropped", wordOf(0), expW[0]);

    // R10 restart while busy
    cfgPageSel = 2'd3;
    startCmd(8'h80);
    fillPat(61);
    sendChunk(CHUNK, 0);
    check("R10 pre-restart valid", 32'(wordOf(0)[30]), 1);
    startCmd(8'h00);
    check("R10 cleared", wordOf(0), 0);
    check("R10 busy", 32'(eccBusy), 1);
    fillPat(67);
    expW[0] = refWord(CHUNK, 0);
    sendChunk(CHUNK, 1);
    check("R10 word0", wordOf(0), expW[0]);
    check("R10 done", 32'(eccBusy), 0);

    // R2 programmable opcode
    opWrStart = 8'h42;
    startCmd(8'h80);
    check("R2 old opcode", 32'(eccBusy), 0);
    startCmd(8'h42);
    check("R2 new opcode", 32'(eccBusy), 1);
    sendChunk(4, 1);
    check("R2 closed", 32'(eccBusy), 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule